// File: doc/BRIEF.md
# Dual-Port Control Register Bank

This block holds a small set of 64-bit control and status registers that two agents reach through one shared decoder: a privileged scan-style port and a memory-mapped port. The shared front end presents one 8-byte access per cycle, tagged with the port it arrived on. The two ports translate their byte addresses into register indices differently. The privileged port uses the byte address shifted right by three. The memory-mapped port adds ten to that shifted value.

Besides plain read/write registers, the bank offers write-only alias indices. These AND, OR, set or clear bits of a shared register in one access, so software avoids a read-modify-write sequence. The base address register stores only its legal address field and an enable bit. It can be changed only from the privileged port. Its enable bit and address field are driven out for the address-map logic that sits outside this block. Rejected and unimplemented accesses each raise a one-cycle flag. A change of the memory-mapped-enable control bit raises a one-cycle notify pulse.

Top module: `dualport_csr_bank`

## Requirements
- R1: Register index: for the privileged port (accFromMmio=0) it is accAddr>>3. For the memory-mapped port (accFromMmio=1) it is (accAddr>>3)+0x0a. Address bits [2:0] are ignored.
- R2: Index 0x00 is the fault register, readable and writable. A write to index 0x01 replaces it with (fault AND data). A write to index 0x02 replaces it with (fault OR data).
- R3: Index 0x0e is the control register, readable and writable. A write to index 0x12 ORs the data into it. A write to index 0x13 clears the bits that are set in the data.
- R4: Index 0x0a is the base register. A privileged write stores data AND (0x0003fffffff00000 OR 1). A memory-mapped write leaves it unchanged and pulses rejectFlag.
- R5: Index 0x0b is the secondary base register. A write stores data AND 0x0003ffff00000000.
- R6: Index 0x15 reads the value of statusIn captured on the previous clock edge. A write to it changes nothing and pulses rejectFlag.
- R7: A read of any other index, including the alias indices 0x01, 0x02, 0x12 and 0x13, returns all ones and pulses unimpFlag. A write to an index with no register or alias pulses unimpFlag and changes no register.
- R8: After reset, every register is zero except the base register. The base register holds (BASE_DEFAULT AND 0x0003fffffff00000) OR 1. All flags and rdValid are low.
- R9: mmEnChange is high for exactly the one cycle after any write that changes control bit 62. Writes that leave bit 62 unchanged do not raise it.
- R10: baseValid equals bit 0 of the base register. baseAddr equals the base register AND 0x0003fffffff00000.
- R11: A read gives rdValid=1 and rdData in the cycle after the access. The flags also appear in that cycle. rdValid is 0 after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access request this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accFromMmio | input | 1 | 1 = memory-mapped port, 0 = privileged port |
| accAddr | input | ADDR_W | Byte address within the port's window |
| accWdata | input | 64 | Write data |
| statusIn | input | 64 | Interrupt status source for the read-only register |
| rdValid | output | 1 | Read data valid |
| rdData | output | 64 | Read data |
| rejectFlag | output | 1 | One-cycle pulse: write refused |
| unimpFlag | output | 1 | One-cycle pulse: no register at that index |
| mmEnChange | output | 1 | One-cycle pulse: control bit 62 changed |
| baseValid | output | 1 | Base register enable bit |
| baseAddr | output | 64 | Masked base address field |

## Verification
The main decode is exercised with the same registers reached from both ports. This separates the two index translations: a memory-mapped read at byte 0x20 must return the control register, not the fault register. The alias writes use data patterns whose AND, OR, set and clear results all differ from a plain overwrite. This exposes an alias wired to the wrong operation. The base and secondary base registers are written with all ones, so each mask shows up bit for bit. A memory-mapped base write and a status write are each followed by a read, which shows the refused write left the stored value alone. The notify pulse is tried with writes that flip bit 62 and with writes that leave it unchanged, through both the set alias and the direct write.

// File: rtl/csrb_pkg.sv
package csrb_pkg;

  localparam int DATA_W = 64;
  localparam int MMEN_BIT = 62;
  localparam int MMIO_IDX_OFS = 10;

  localparam logic [DATA_W-1:0] BASE_MASK = 64'h0003_ffff_fff0_0000;
  localparam logic [DATA_W-1:0] SEC_MASK  = 64'h0003_ffff_0000_0000;

  localparam logic [7:0] IDX_FAULT     = 8'h00;
  localparam logic [7:0] IDX_FAULT_AND = 8'h01;
  localparam logic [7:0] IDX_FAULT_OR  = 8'h02;
  localparam logic [7:0] IDX_BASE      = 8'h0a;
  localparam logic [7:0] IDX_SEC       = 8'h0b;
  localparam logic [7:0] IDX_CTRL      = 8'h0e;
  localparam logic [7:0] IDX_CTRL_SET  = 8'h12;
  localparam logic [7:0] IDX_CTRL_CLR  = 8'h13;
  localparam logic [7:0] IDX_STAT      = 8'h15;

  typedef enum logic [2:0] {
    SEL_ONES,
    SEL_FAULT,
    SEL_BASE,
    SEL_SEC,
    SEL_CTRL,
    SEL_STAT
  } rd_sel_e;

  typedef struct packed {
    logic    wrFault;
    logic    andFault;
    logic    orFault;
    logic    wrCtrl;
    logic    setCtrl;
    logic    clrCtrl;
    logic    wrBase;
    logic    wrSec;
    logic    rdEn;
    rd_sel_e rdSel;
    logic    reject;
    logic    unimp;
  } csrb_strobe_t;

endpackage

// File: rtl/csrb_decode.sv
module csrb_decode
  import csrb_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              accFromMmio,
  input  logic [ADDR_W-1:0] accAddr,
  output csrb_strobe_t      stb
);

  logic [IDX_W-1:0] rawIdx;
  logic [IDX_W-1:0] idx;

  // R1: both ports land in one index space
  assign rawIdx = {1'b0, accAddr[ADDR_W-1:3]};
  assign idx    = accFromMmio ? rawIdx + IDX_W'(MMIO_IDX_OFS) : rawIdx;

  always_comb begin
    stb       = '0;
    stb.rdSel = SEL_ONES;
    if (accValid) begin
      if (accWrite) begin
        case (idx)
          IDX_W'(IDX_FAULT):     stb.wrFault  = 1'b1;
          IDX_W'(IDX_FAULT_AND): stb.andFault = 1'b1;
          IDX_W'(IDX_FAULT_OR):  stb.orFault  = 1'b1;
          IDX_W'(IDX_CTRL):      stb.wrCtrl   = 1'b1;
          IDX_W'(IDX_CTRL_SET):  stb.setCtrl  = 1'b1;
          IDX_W'(IDX_CTRL_CLR):  stb.clrCtrl  = 1'b1;
          IDX_W'(IDX_SEC):       stb.wrSec    = 1'b1;
          IDX_W'(IDX_BASE): begin
            if (accFromMmio) stb.reject = 1'b1;
            else             stb.wrBase = 1'b1;
          end
          IDX_W'(IDX_STAT):      stb.reject   = 1'b1;
          default:               stb.unimp    = 1'b1;
        endcase
      end else begin
        stb.rdEn = 1'b1;
        case (idx)
          IDX_W'(IDX_FAULT): stb.rdSel = SEL_FAULT;
          IDX_W'(IDX_BASE):  stb.rdSel = SEL_BASE;
          IDX_W'(IDX_SEC):   stb.rdSel = SEL_SEC;
          IDX_W'(IDX_CTRL):  stb.rdSel = SEL_CTRL;
          IDX_W'(IDX_STAT):  stb.rdSel = SEL_STAT;
          default:           stb.unimp = 1'b1;
        endcase
      end
    end
  end

  // R2: at most one update action per access
  p_single_action_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrFault, stb.andFault, stb.orFault, stb.wrCtrl, stb.setCtrl,
              stb.clrCtrl, stb.wrBase, stb.wrSec, stb.reject, stb.unimp, stb.rdEn && !stb.unimp}));

  // R4: the memory-mapped port never reaches the base write strobe
  p_mmio_no_base_r4: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accFromMmio) |-> !stb.wrBase);

  // R11: idle cycles produce no strobe
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (stb == csrb_strobe_t'(0)));

endmodule

// File: rtl/csrb_regs.sv
module csrb_regs
  import csrb_pkg::*;
#(
  parameter logic [DATA_W-1:0] BASE_DEFAULT = 64'h0000_0000_8000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrb_strobe_t      stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] statusIn,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rejectFlag,
  output logic              unimpFlag,
  output logic              mmEnChange,
  output logic              baseValid,
  output logic [DATA_W-1:0] baseAddr
);

  localparam logic [DATA_W-1:0] BASE_KEEP = BASE_MASK | DATA_W'(1);
  localparam logic [DATA_W-1:0] BASE_RST  = (BASE_DEFAULT & BASE_MASK) | DATA_W'(1);

  logic [DATA_W-1:0] faultReg, ctrlReg, baseReg, secReg, statReg;
  logic [DATA_W-1:0] faultNext, ctrlNext, rdMux;

  always_comb begin
    faultNext = faultReg;
    if (stb.wrFault)       faultNext = wdata;
    else if (stb.andFault) faultNext = faultReg & wdata;
    else if (stb.orFault)  faultNext = faultReg | wdata;
  end

  always_comb begin
    ctrlNext = ctrlReg;
    if (stb.wrCtrl)       ctrlNext = wdata;
    else if (stb.setCtrl) ctrlNext = ctrlReg | wdata;
    else if (stb.clrCtrl) ctrlNext = ctrlReg & ~wdata;
  end

  always_comb begin
    case (stb.rdSel)
      SEL_FAULT: rdMux = faultReg;
      SEL_BASE:  rdMux = baseReg;
      SEL_SEC:   rdMux = secReg;
      SEL_CTRL:  rdMux = ctrlReg;
      SEL_STAT:  rdMux = statReg;
      default:   rdMux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultReg   <= '0;
      ctrlReg    <= '0;
      baseReg    <= BASE_RST;
      secReg     <= '0;
      statReg    <= '0;
      rdValid    <= 1'b0;
      rdData     <= '0;
      rejectFlag <= 1'b0;
      unimpFlag  <= 1'b0;
      mmEnChange <= 1'b0;
    end else begin
      faultReg   <= faultNext;
      ctrlReg    <= ctrlNext;
      statReg    <= statusIn;
      if (stb.wrBase) baseReg <= wdata & BASE_KEEP;
      if (stb.wrSec)  secReg  <= wdata & SEC_MASK;
      mmEnChange <= ctrlNext[MMEN_BIT] ^ ctrlReg[MMEN_BIT];
      rdValid    <= stb.rdEn;
      rdData     <= stb.rdEn ? rdMux : '0;
      rejectFlag <= stb.reject;
      unimpFlag  <= stb.unimp;
    end
  end

  assign baseValid = baseReg[0];
  assign baseAddr  = baseReg & BASE_MASK;

  p_base_masked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (baseReg & ~BASE_KEEP) == '0);

  p_reject_keeps_base_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.reject |=> $stable(baseReg));

  p_sec_masked_r5: assert property (@(posedge clk) disable iff (!rstN)
    (secReg & ~SEC_MASK) == '0);

  p_unimp_ones_r7: assert property (@(posedge clk) disable iff (!rstN)
    (unimpFlag && rdValid) |-> (rdData == '1));

  p_flags_apart_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(rejectFlag && unimpFlag));

  p_notify_on_flip_r9: assert property (@(posedge clk) disable iff (!rstN)
    mmEnChange |-> (ctrlReg[MMEN_BIT] != $past(ctrlReg[MMEN_BIT])));

  p_write_no_rdvalid_r11: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> !rdValid);

endmodule

// File: rtl/dualport_csr_bank.sv
module dualport_csr_bank
  import csrb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [63:0] BASE_DEFAULT = 64'h0000_0000_8000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              accFromMmio,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [63:0]       accWdata,
  input  logic [63:0]       statusIn,
  output logic              rdValid,
  output logic [63:0]       rdData,
  output logic              rejectFlag,
  output logic              unimpFlag,
  output logic              mmEnChange,
  output logic              baseValid,
  output logic [63:0]       baseAddr
);

  csrb_strobe_t stb;

  csrb_decode #(.ADDR_W(ADDR_W)) uDecode (
    .clk         (clk),
    .rstN        (rstN),
    .accValid    (accValid),
    .accWrite    (accWrite),
    .accFromMmio (accFromMmio),
    .accAddr     (accAddr),
    .stb         (stb)
  );

  csrb_regs #(.BASE_DEFAULT(BASE_DEFAULT)) uRegs (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wdata      (accWdata),
    .statusIn   (statusIn),
    .rdValid    (rdValid),
    .rdData     (rdData),
    .rejectFlag (rejectFlag),
    .unimpFlag  (unimpFlag),
    .mmEnChange (mmEnChange),
    .baseValid  (baseValid),
    .baseAddr   (baseAddr)
  );

  // R10: the base outputs never show a bit outside the legal field
  p_base_addr_field_r10: assert property (@(posedge clk) disable iff (!rstN)
    (baseAddr & ~BASE_MASK) == '0);

endmodule

// File: tb/sim_dualport_csr_bank.sv
module sim_dualport_csr_bank;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;
  localparam logic [63:0] STAT_PAT = 64'h0000_0012_3400_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0, accWrite = 1'b0, accFromMmio = 1'b0;
  logic [7:0] accAddr = '0;
  logic [63:0] accWdata = '0;
  logic [63:0] statusIn = STAT_PAT;
  logic rdValid, rejectFlag, unimpFlag, mmEnChange, baseValid;
  logic [63:0] rdData, baseAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dualport_csr_bank u0 (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accFromMmio(accFromMmio), .accAddr(accAddr), .accWdata(accWdata),
    .statusIn(statusIn), .rdValid(rdValid), .rdData(rdData),
    .rejectFlag(rejectFlag), .unimpFlag(unimpFlag), .mmEnChange(mmEnChange),
    .baseValid(baseValid), .baseAddr(baseAddr)
  );

  typedef struct packed {
    logic        wr;
    logic        mm;
    logic [7:0]  addr;
    logic [63:0] wd;
    logic [63:0] exp;
    logic        rej;
    logic        unimp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 23;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b0, 8'h00, 64'h0, 64'h0, 1'b0, 1'b0, 4'd8},                                     // R8 fault at reset
    '{1'b1, 1'b0, 8'h00, 64'hF0F0_0000_0000_FFFF, 64'h0, 1'b0, 1'b0, 4'd2},                   // R2 write
    '{1'b1, 1'b0, 8'h08, 64'hFF00_FF00_FF00_FF00, 64'h0, 1'b0, 1'b0, 4'd2},                   // R2 AND alias
    '{1'b1, 1'b0, 8'h10, 64'h0000_0000_1234_0000, 64'h0, 1'b0, 1'b0, 4'd2},                   // R2 OR alias
    '{1'b0, 1'b0, 8'h00, 64'h0, 64'hF000_0000_1234_FF00, 1'b0, 1'b0, 4'd2},                   // R2 result
    '{1'b1, 1'b0, 8'h70, 64'h0000_0000_0000_00F0, 64'h0, 1'b0, 1'b0, 4'd3},                   // R3 write
    '{1'b1, 1'b0, 8'h90, 64'h0000_0000_0000_0F0F, 64'h0, 1'b0, 1'b0, 4'd3},                   // R3 set alias
    '{1'b1, 1'b0, 8'h98, 64'h0000_0000_0000_0F00, 64'h0, 1'b0, 1'b0, 4'd3},                   // R3 clear alias
    '{1'b0, 1'b1, 8'h20, 64'h0, 64'h0000_0000_0000_00FF, 1'b0, 1'b0, 4'd1},                   // R1 mmio 0x20 -> ctrl
    '{1'b1, 1'b0, 8'h50, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0, 1'b0, 1'b0, 4'd4},                   // R4 base write
    '{1'b0, 1'b0, 8'h50, 64'h0, 64'h0003_FFFF_FFF0_0000, 1'b0, 1'b0, 4'd4},                   // R4 masked
    '{1'b1, 1'b1, 8'h00, 64'h0000_0000_0000_0001, 64'h0, 1'b1, 1'b0, 4'd4},                   // R4 mmio rejected
    '{1'b0, 1'b1, 8'h00, 64'h0, 64'h0003_FFFF_FFF0_0000, 1'b0, 1'b0, 4'd4},                   // R4 unchanged (R1)
    '{1'b1, 1'b0, 8'h58, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 1'b0, 4'd5},                   // R5 write
    '{1'b0, 1'b1, 8'h08, 64'h0, 64'h0003_FFFF_0000_0000, 1'b0, 1'b0, 4'd5},                   // R5 masked via mmio
    '{1'b1, 1'b0, 8'hA8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b0, 4'd6},                   // R6 write refused
    '{1'b0, 1'b0, 8'hA8, 64'h0, STAT_PAT, 1'b0, 1'b0, 4'd6},                                  // R6 read
    '{1'b0, 1'b1, 8'h58, 64'h0, STAT_PAT, 1'b0, 1'b0, 4'd6},                                  // R6 read via mmio
    '{1'b0, 1'b0, 8'h08, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 4'd7},                   // R7 alias read
    '{1'b0, 1'b0, 8'h30, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 4'd7},                   // R7 hole
    '{1'b1, 1'b0, 8'hF8, 64'h1234, 64'h0, 1'b0, 1'b1, 4'd7},                                  // R7 write hole
    '{1'b0, 1'b1, 8'hF8, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 4'd7},                   // R7 mmio beyond
    '{1'b0, 1'b0, 8'h00, 64'h0, 64'hF000_0000_1234_FF00, 1'b0, 1'b0, 4'd7}                    // R7 fault untouched
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge where results are visible
  task automatic access(input logic wr, input logic mm, input logic [7:0] addr, input logic [63:0] wd);
    accValid = 1'b1; accWrite = wr; accFromMmio = mm; accAddr = addr; accWdata = wd;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R8 reset state, R10 base outputs
    chk("R8 rdValid", 64'(rdValid), 64'd0);
    chk("R8 flags", {62'd0, rejectFlag, unimpFlag}, 64'd0);
    chk("R10 baseValid", 64'(baseValid), 64'd1);
    chk("R10 baseAddr", baseAddr, 64'h0000_0000_8000_0000);
    access(1'b0, 1'b0, 8'h50, 64'h0);
    chk("R8 base reset", rdData, 64'h0000_0000_8000_0001);
    access(1'b0, 1'b0, 8'h70, 64'h0);
    chk("R8 ctrl reset", rdData, 64'h0);
    access(1'b0, 1'b1, 8'h08, 64'h0);
    chk("R8 sec reset", rdData, 64'h0);

    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i].wr, VEC[i].mm, VEC[i].addr, VEC[i].wd);
      checks++;
      if (rdValid !== !VEC[i].wr || rejectFlag !== VEC[i].rej || unimpFlag !== VEC[i].unimp ||
          (!VEC[i].wr && rdData !== VEC[i].exp)) begin
        errors++;
        $display("FAIL R%0d vec %0d: actual v=%b d=%h rej=%b un=%b expected v=%b d=%h rej=%b un=%b",
                 VEC[i].req, i, rdValid, rdData, rejectFlag, unimpFlag,
                 !VEC[i].wr, VEC[i].exp, VEC[i].rej, VEC[i].unimp);
      end
    end

    // R11 idle cycle drops rdValid
    @(negedge clk);
    chk("R11 idle rdValid", 64'(rdValid), 64'd0);

    // R10 after base write with enable clear, then a fresh enabled value
    chk("R10 baseValid off", 64'(baseValid), 64'd0);
    chk("R10 baseAddr all", baseAddr, 64'h0003_FFFF_FFF0_0000);
    access(1'b1, 1'b0, 8'h50, 64'h0000_0000_0010_0001);
    chk("R10 baseValid on", 64'(baseValid), 64'd1);
    chk("R10 baseAddr new", baseAddr, 64'h0000_0000_0010_0000);

    // R9 change notify
    access(1'b1, 1'b0, 8'h90, 64'h4000_0000_0000_0000);
    chk("R9 set flips bit62", 64'(mmEnChange), 64'd1);
    @(negedge clk);
    chk("R9 pulse one cycle", 64'(mmEnChange), 64'd0);
    access(1'b1, 1'b0, 8'h90, 64'h4000_0000_0000_0000);
    chk("R9 set no change", 64'(mmEnChange), 64'd0);
    access(1'b1, 1'b0, 8'h70, 64'h0000_0000_0000_0001);
    chk("R9 write clears bit62", 64'(mmEnChange), 64'd1);
    access(1'b1, 1'b0, 8'h98, 64'h0000_0000_0000_0001);
    chk("R9 clear no change", 64'(mmEnChange), 64'd0);
    access(1'b0, 1'b0, 8'h70, 64'h0);
    chk("R3 ctrl final", rdData, 64'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule